// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer

This block decides when an external successive-approximation converter is told to begin a conversion and which analog input it samples. A mask with one bit per input names the inputs taking part in rotation. After each completed conversion the block rewrites its current-channel field to the next enabled input, searching upward and wrapping. With an empty mask the field stays where it was put.

Conversions are requested in one of three ways. A one-cycle single-shot request starts one conversion. A continuous-mode level starts a new conversion as soon as the previous one finishes. Continuous mode can also be paced, so that a conversion starts only on a pacing tick from an external divider. The block captures the converter's result word and error flag on each completion and keeps a sticky error flag that software clears by writing 1. The pacing divider and any result queue sit outside this block.

Top module: `adc_rr_sequencer`

## Requirements
- R1: While the rotation mask is all zero and no select write occurs, `chan_sel` holds its value across conversions.
- R2: With a non-zero mask, a conversion samples the channel held in `chan_sel` when `conv_start` pulses. On completion, `chan_sel` becomes the first enabled channel found by checking (current+1), (current+2) and so on, each taken modulo 5. If only one channel is enabled, it repeats. A current value of 5 to 7 enters the same modulo search.
- R3: A pulse on `sel_wr` loads `sel_wdata` into `chan_sel` on the next clock edge. If it coincides with a completion, the write takes priority.
- R4: A one-cycle `start_once` starts one conversion when `ready` is 1. It is dropped (not held pending) when `ready` is 0 or when `start_many` is 1.
- R5: With `start_many`=1 and `paced`=0, `conv_start` pulses in the clock cycle immediately after the cycle in which `conv_done` was accepted.
- R6: With `start_many`=1 and `paced`=1, a conversion starts only in a cycle where `pace_tick` is 1 and `ready` is 1. Ticks arriving during a conversion are lost.
- R7: `ready` is 1 when the block is enabled and idle. It is 0 from the cycle after `conv_start` until the cycle after `conv_done` is accepted. `conv_start` only pulses while `ready` is 1.
- R8: While `cfg_enable` is 0, `conv_start` stays 0 and `ready` reads 0.
- R9: On an accepted completion, `result` takes the 12-bit `conv_data` value on the next clock edge and holds it until the next completion.
- R10: `err_live` equals the `conv_err` value of the most recent accepted completion.
- R11: `err_sticky` is set by any accepted completion with `conv_err`=1. It is cleared by `err_clr`=1. If a set and a clear fall in the same cycle, the set wins.
- R12: After reset, `chan_sel`, `result`, `err_live` and `err_sticky` are 0 and the block is idle.
- R13: `conv_start` is a single-cycle pulse. A `conv_done` arriving while no conversion is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Converter powered and sequencer enabled |
| rr_mask | input | 5 | Rotation mask, bit n enables channel n |
| sel_wr | input | 1 | Load strobe for the current-channel field |
| sel_wdata | input | 3 | Value loaded into the current-channel field |
| start_once | input | 1 | One-cycle single-conversion request |
| start_many | input | 1 | Continuous conversion mode level |
| paced | input | 1 | 1 when the external pacing divisor is non-zero |
| pace_tick | input | 1 | Pacing tick from the external divider |
| conv_done | input | 1 | Converter signals completion |
| conv_data | input | 12 | Converter result, valid with conv_done |
| conv_err | input | 1 | Converter error, valid with conv_done |
| err_clr | input | 1 | Clears the sticky error flag |
| conv_start | output | 1 | Start strobe to the converter |
| chan_sel | output | 3 | Current channel / analog mux select |
| ready | output | 1 | Idle and able to start a conversion |
| result | output | 12 | Result of the latest conversion |
| err_live | output | 1 | Error flag of the latest conversion |
| err_sticky | output | 1 | Accumulated error flag |

## Verification
The bound checker watches, on every cycle, the arbitration rules: no start while disabled, without ready, or without a tick in paced mode. It also checks that the start strobe is one cycle wide, that the result and both error flags capture on each accepted completion, and that a stray completion while idle leaves the result unchanged. It further checks that the channel field holds with an empty mask and lands on an enabled channel otherwise. Only the bench scenarios show the exact order of channels through a rotation, the modulo wrap from out-of-range values, the one-cycle gap of back-to-back mode, and the loss of single-shot requests and ticks that arrive while busy.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_state_e;

  // Next channel in rotation: first enabled index at (cur+k) mod nch, k = 1..nch.
  // Supports up to 8 channels; with a single enabled bit the search returns it.
  function automatic logic [7:0] rr_next(input logic [7:0] cur,
                                         input logic [7:0] mask,
                                         input int         nch);
    logic [7:0] res;
    int         pos;
    res = cur;
    for (int k = 8; k >= 1; k--) begin
      if (k <= nch) begin
        pos = (int'(cur) + k) % nch;
        if (mask[pos[2:0]]) res = 8'(pos);
      end
    end
    return res;
  endfunction

  // Start arbitration: continuous mode overrides single-shot requests.
  function automatic logic start_decide(input logic can_start,
                                        input logic once,
                                        input logic many,
                                        input logic is_paced,
                                        input logic tick);
    logic go;
    if (!can_start)    go = 1'b0;
    else if (many)     go = is_paced ? tick : 1'b1;
    else               go = once;
    return go;
  endfunction

endpackage

// File: rtl/adc_seq_arbiter.sv
module adc_seq_arbiter (
  input  logic enable,
  input  logic idle,
  input  logic start_once,
  input  logic start_many,
  input  logic paced,
  input  logic pace_tick,
  output logic ready,
  output logic fire
);
  import adc_seq_pkg::*;

  always_comb begin
    ready = enable && idle;
    fire  = start_decide(ready, start_once, start_many, paced, pace_tick);
  end

endmodule

// File: rtl/adc_seq_chan_rotator.sv
module adc_seq_chan_rotator #(
  parameter int NCH = 5,
  parameter int CW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] mask,
  input  logic           sel_wr,
  input  logic [CW-1:0]  sel_wdata,
  input  logic           advance,
  output logic [CW-1:0]  chan
);
  import adc_seq_pkg::*;

  logic [CW-1:0] chan_q;
  logic [7:0]    nxt_wide;
  logic [CW-1:0] chan_nxt;
  logic          rotate_on;

  always_comb begin
    rotate_on = |mask;
    nxt_wide  = rr_next(8'(chan_q), 8'(mask), NCH);
    chan_nxt  = nxt_wide[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      chan_q <= '0;
    else if (sel_wr)                 chan_q <= sel_wdata;
    else if (advance && rotate_on)   chan_q <= chan_nxt;
  end

  assign chan = chan_q;

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [RW-1:0] data,
  input  logic          err,
  input  logic          err_clr,
  output logic [RW-1:0] result,
  output logic          err_live,
  output logic          err_sticky
);

  logic [RW-1:0] result_q;
  logic          live_q;
  logic          sticky_q;
  logic          set_ev;

  assign set_ev = capture && err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      live_q   <= 1'b0;
    end else if (capture) begin
      result_q <= data;
      live_q   <= err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sticky_q <= 1'b0;
    else if (set_ev)  sticky_q <= 1'b1;
    else if (err_clr) sticky_q <= 1'b0;
  end

  assign result     = result_q;
  assign err_live   = live_q;
  assign err_sticky = sticky_q;

endmodule

// File: rtl/adc_rr_sequencer.sv
module adc_rr_sequencer #(
  parameter int NCH = 5,
  parameter int RW  = 12,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_enable,
  input  logic [NCH-1:0] rr_mask,
  input  logic           sel_wr,
  input  logic [CW-1:0]  sel_wdata,
  input  logic           start_once,
  input  logic           start_many,
  input  logic           paced,
  input  logic           pace_tick,
  input  logic           conv_done,
  input  logic [RW-1:0]  conv_data,
  input  logic           conv_err,
  input  logic           err_clr,
  output logic           conv_start,
  output logic [CW-1:0]  chan_sel,
  output logic           ready,
  output logic [RW-1:0]  result,
  output logic           err_live,
  output logic           err_sticky
);
  import adc_seq_pkg::*;

  seq_state_e state_q;
  logic       idle;
  logic       start_fire;
  logic       done_ev;

  assign idle    = (state_q == ST_IDLE);
  assign done_ev = conv_done && !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= ST_IDLE;
    else if (start_fire) state_q <= ST_BUSY;
    else if (done_ev)    state_q <= ST_IDLE;
  end

  adc_seq_arbiter u_arb (
    .enable     (cfg_enable),
    .idle       (idle),
    .start_once (start_once),
    .start_many (start_many),
    .paced      (paced),
    .pace_tick  (pace_tick),
    .ready      (ready),
    .fire       (start_fire)
  );

  adc_seq_chan_rotator #(.NCH(NCH), .CW(CW)) u_rot (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask      (rr_mask),
    .sel_wr    (sel_wr),
    .sel_wdata (sel_wdata),
    .advance   (done_ev),
    .chan      (chan_sel)
  );

  adc_seq_result #(.RW(RW)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (done_ev),
    .data       (conv_data),
    .err        (conv_err),
    .err_clr    (err_clr),
    .result     (result),
    .err_live   (err_live),
    .err_sticky (err_sticky)
  );

  assign conv_start = start_fire;

endmodule

// File: rtl/adc_rr_sequencer_chk.sv
module adc_rr_sequencer_chk #(
  parameter int NCH = 5,
  parameter int RW  = 12,
  parameter int CW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_enable,
  input logic [NCH-1:0] rr_mask,
  input logic           sel_wr,
  input logic           start_once,
  input logic           start_many,
  input logic           paced,
  input logic           pace_tick,
  input logic           conv_done,
  input logic [RW-1:0]  conv_data,
  input logic           conv_err,
  input logic           err_clr,
  input logic           conv_start,
  input logic [CW-1:0]  chan_sel,
  input logic           ready,
  input logic [RW-1:0]  result,
  input logic           err_live,
  input logic           err_sticky,
  input logic           fire_ev,
  input logic           done_ev
);

  logic [NCH-1:0] mask_q;
  always_ff @(posedge clk) mask_q <= rr_mask;

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> (!conv_start && !ready));

  // R7
  start_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ready);

  // R7
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ev |=> !ready);

  // R13
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R13
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !done_ev) |=> $stable(result));

  // R9
  result_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (result == $past(conv_data)));

  // R10
  err_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (err_live == $past(conv_err)));

  // R11
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && conv_err) |=> err_sticky);

  // R11
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(done_ev && conv_err)) |=> !err_sticky);

  // R1
  mask_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rr_mask == '0) && !sel_wr) |=> $stable(chan_sel));

  // R2
  lands_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && (rr_mask != '0) && !sel_wr) |=> mask_q[chan_sel]);

  // R6
  pace_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_many && paced && !pace_tick) |-> !conv_start);

  // R4
  once_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_once && !ready) |-> !conv_start);

endmodule

bind adc_rr_sequencer adc_rr_sequencer_chk #(.NCH(NCH), .RW(RW), .CW(CW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_enable (cfg_enable),
  .rr_mask    (rr_mask),
  .sel_wr     (sel_wr),
  .start_once (start_once),
  .start_many (start_many),
  .paced      (paced),
  .pace_tick  (pace_tick),
  .conv_done  (conv_done),
  .conv_data  (conv_data),
  .conv_err   (conv_err),
  .err_clr    (err_clr),
  .conv_start (conv_start),
  .chan_sel   (chan_sel),
  .ready      (ready),
  .result     (result),
  .err_live   (err_live),
  .err_sticky (err_sticky),
  .fire_ev    (start_fire),
  .done_ev    (done_ev)
);

// File: tb/adc_rr_sequencer_tb_top.sv
module adc_rr_sequencer_tb_top;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [4:0]  rr_mask = '0;
  logic        sel_wr = 1'b0;
  logic [2:0]  sel_wdata = '0;
  logic        start_once = 1'b0;
  logic        start_many = 1'b0;
  logic        paced = 1'b0;
  logic        pace_tick = 1'b0;
  logic        err_clr = 1'b0;
  logic        conv_done, conv_err;
  logic [11:0] conv_data;
  logic        conv_start, ready, err_live, err_sticky;
  logic [2:0]  chan_sel;
  logic [11:0] result;

  // converter model state
  logic        m_done = 1'b0, m_err = 1'b0, err_next = 1'b0;
  logic [11:0] m_data = '0, m_pend = '0;
  logic        inj_done = 1'b0;
  logic [11:0] inj_data = '0;
  int          m_cnt = 0, n_starts = 0, cyc = 0, done_edge = 0, last_gap = 0;
  logic [2:0]  start_ch = '0;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign conv_done = m_done | inj_done;
  assign conv_data = inj_done ? inj_data : m_data;
  assign conv_err  = inj_done ? 1'b0 : m_err;

  adc_rr_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .rr_mask(rr_mask),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .start_once(start_once),
    .start_many(start_many), .paced(paced), .pace_tick(pace_tick),
    .conv_done(conv_done), .conv_data(conv_data), .conv_err(conv_err),
    .err_clr(err_clr), .conv_start(conv_start), .chan_sel(chan_sel),
    .ready(ready), .result(result), .err_live(err_live), .err_sticky(err_sticky)
  );

  // Fixed-latency converter responder
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (conv_start) begin
      m_cnt    <= LAT;
      n_starts <= n_starts + 1;
      start_ch <= chan_sel;
      last_gap <= cyc - done_edge;
      m_pend   <= 12'h3C5 ^ {chan_sel, 9'(n_starts * 13 + 7)};
    end else if (m_cnt != 0) begin
      m_cnt <= m_cnt - 1;
    end
    m_done <= (m_cnt == 1);
    if (m_cnt == 1) begin
      m_data    <= m_pend;
      m_err     <= err_next;
      done_edge <= cyc + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 60 && !ready; i++) @(negedge clk);
  endtask

  task automatic pulse_sel(input logic [2:0] v);
    sel_wdata = v; sel_wr = 1'b1;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  // One single-shot conversion; returns at a negedge with the block idle again.
  task automatic run_once();
    start_once = 1'b1;
    @(negedge clk); start_once = 1'b0;
    check(ready == 1'b0, "R7 busy", int'(ready), 0);
    wait_ready();
  endtask

  // {mask[4:0], sel0[2:0], ch_after1, ch_after2, ch_after3}
  localparam logic [16:0] VEC [8] = '{
    {5'b11111, 3'd0, 3'd1, 3'd2, 3'd3},
    {5'b10101, 3'd0, 3'd2, 3'd4, 3'd0},
    {5'b00100, 3'd2, 3'd2, 3'd2, 3'd2},
    {5'b00100, 3'd0, 3'd2, 3'd2, 3'd2},
    {5'b00000, 3'd3, 3'd3, 3'd3, 3'd3},
    {5'b10010, 3'd4, 3'd1, 3'd4, 3'd1},
    {5'b01000, 3'd7, 3'd3, 3'd3, 3'd3},
    {5'b00011, 3'd1, 3'd0, 3'd1, 3'd0}
  };

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(chan_sel == 0, "R12 chan", int'(chan_sel), 0);
    check(result == 0, "R12 result", int'(result), 0);
    check(!err_live && !err_sticky, "R12 errs", int'({err_live, err_sticky}), 0);
    // R8 disabled
    check(ready == 0, "R8 ready off", int'(ready), 0);
    s0 = n_starts;
    start_once = 1'b1; @(negedge clk); start_once = 1'b0;
    repeat (3) @(negedge clk);
    check(n_starts == s0, "R8 no start", n_starts, s0);
    cfg_enable = 1'b1;
    @(negedge clk);
    check(ready == 1, "R7 ready idle", int'(ready), 1);

    // Vector walk: rotation order (R1, R2, R3, R9)
    foreach (VEC[v]) begin
      logic [2:0] exp_ch [4];
      rr_mask   = VEC[v][16:12];
      exp_ch[0] = VEC[v][11:9];
      exp_ch[1] = VEC[v][8:6];
      exp_ch[2] = VEC[v][5:3];
      exp_ch[3] = VEC[v][2:0];
      pulse_sel(exp_ch[0]);
      check(chan_sel == exp_ch[0], "R3 sel write", int'(chan_sel), int'(exp_ch[0]));
      for (int k = 0; k < 3; k++) begin
        run_once();
        check(start_ch == exp_ch[k], "R2 start channel", int'(start_ch), int'(exp_ch[k]));
        check(chan_sel == exp_ch[k+1],
              (rr_mask == 0) ? "R1 hold" : "R2 next channel",
              int'(chan_sel), int'(exp_ch[k+1]));
        check(result == m_pend, "R9 result", int'(result), int'(m_pend));
      end
    end

    // R10 / R11 error flags
    rr_mask = 5'b00001;
    err_next = 1'b1; run_once();
    check(err_live == 1 && err_sticky == 1, "R10 err set", int'({err_live, err_sticky}), 3);
    err_next = 1'b0; run_once();
    check(err_live == 0, "R10 err follows latest", int'(err_live), 0);
    check(err_sticky == 1, "R11 sticky kept", int'(err_sticky), 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check(err_sticky == 0, "R11 sticky cleared", int'(err_sticky), 0);

    // R13 stray completion while idle
    inj_data = 12'hABC; inj_done = 1'b1;
    @(negedge clk); inj_done = 1'b0;
    check(result == m_pend, "R13 stray done ignored", int'(result), int'(m_pend));

    // R4 dropped while busy
    s0 = n_starts;
    start_once = 1'b1; @(negedge clk); start_once = 1'b0;
    start_once = 1'b1; @(negedge clk); start_once = 1'b0;
    wait_ready(); repeat (2) @(negedge clk);
    check(n_starts == s0 + 1, "R4 busy request dropped", n_starts, s0 + 1);

    // R4 / R6: continuous paced mode, no tick
    start_many = 1'b1; paced = 1'b1;
    s0 = n_starts;
    start_once = 1'b1; @(negedge clk); start_once = 1'b0;
    repeat (10) @(negedge clk);
    check(n_starts == s0, "R4 once ignored in continuous", n_starts, s0);
    pace_tick = 1'b1; @(negedge clk); pace_tick = 1'b0;
    check(n_starts == s0 + 1, "R6 tick starts", n_starts, s0 + 1);
    pace_tick = 1'b1; @(negedge clk); pace_tick = 1'b0;
    wait_ready(); repeat (4) @(negedge clk);
    check(n_starts == s0 + 1, "R6 busy tick lost", n_starts, s0 + 1);

    // R5 back-to-back
    paced = 1'b0;
    @(negedge clk);
    s0 = n_starts;
    for (int j = 0; j < 4; j++) begin
      while (n_starts == s0 + j) @(negedge clk);
      if (j > 0) check(last_gap == 1, "R5 back-to-back gap", last_gap, 1);
    end
    start_many = 1'b0;
    wait_ready();
    repeat (3) @(negedge clk);
    check(ready == 1, "R7 ready after stop", int'(ready), 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule